// File: doc/BRIEF.md
# Selective Thermal Shutdown Controller

This block decides which regulator channels are switched off when the die overheats and when they are allowed back on. It watches two digital temperature flags from an analog sensor: one that rises when the die is too hot (around 145 °C), and one that rises once the die has cooled well below that (around 110 °C). The gap between the two thresholds is the hysteresis. For each channel it also reads a flag that is high while that channel's load current is above the light-load threshold (50 mA).

When overheat is declared, only the heavily loaded channels are turned off, and lightly loaded channels keep regulating. If every channel is heavily loaded, all of them are turned off. If no channel is heavily loaded, the heat source is unknown, so all channels are turned off as well. The chosen set is captured once, at the moment of overheat entry. It is held until the cooled-down flag is seen while the overheat flag is low. Release then clears every thermal disable together and gives each released channel a one-cycle pulse that starts a fresh soft-start.

The two temperature flags come from another clock domain. Each passes through a two-flop synchronizer. The load flags are taken to be synchronous to `clk` already.

Top module: `therm_guard`

## Requirements
- R1: While `rst_n` is low at a clock edge, and in the cycle after that edge, `therm_off_o` and `restart_o` are all zero.
- R2: A change on `hot_i` or `cool_i` reaches the outputs on the third rising edge after the change (two synchronizer flops and one state register). Two edges after the change the outputs have not yet responded.
- R3: On overheat entry, `therm_off_o[i]` goes to 1 for each channel i whose `heavy_i[i]` is 1. Channels with `heavy_i[i]` = 0 keep `therm_off_o[i]` = 0. Bit i of every vector is channel i.
- R4: If every `heavy_i` bit is 1 at overheat entry, every `therm_off_o` bit goes to 1.
- R5: If no `heavy_i` bit is 1 at overheat entry, every `therm_off_o` bit goes to 1.
- R6: While tripped, `therm_off_o` holds the set captured at entry. Later changes on `heavy_i`, and `hot_i` falling, do not change it.
- R7: `cool_i` has no effect while the block is not tripped, and no effect while the synchronized `hot_i` is still high. `therm_off_o` and `restart_o` stay unchanged in both cases.
- R8: On release, `therm_off_o` becomes all zero in the same cycle that `restart_o` equals the captured set. `restart_o` is zero in the following cycle, and `restart_o` never has a bit set for a channel that was not disabled.
- R9: After a release, a new overheat captures a new set from the `heavy_i` value present at that new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hot_i | input | 1 | Overheat flag, asynchronous |
| cool_i | input | 1 | Cooled-down flag, asynchronous |
| heavy_i | input | NUM_CH | Per-channel load-above-threshold flag |
| therm_off_o | output | NUM_CH | Per-channel thermal disable |
| restart_o | output | NUM_CH | Per-channel one-cycle soft-start request |

## Verification
The bench changes the temperature flags just after a falling edge. It samples the outputs after the second rising edge, where nothing may have changed yet, and again after the third rising edge, where the trip or the release must be visible. This pins the three-register latency exactly. The restart pulse is checked in the release cycle and in the cycle after it, so its width is verified as well. Load flags are held steady through each entry edge and then changed while tripped, to show that the captured set does not follow them. Checks that something is ignored wait several cycles past the point where an effect would appear.

// File: rtl/thsd_pkg.sv
// Shared types for the selective thermal shutdown controller.
package thsd_pkg;
    // Controller state: regulating normally, or holding a thermal disable.
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_TRIP = 1'b1
    } trip_state_e;
endpackage

// File: rtl/thsd_sync.sv
// Multi-flop synchronizer for level flags from another clock domain.
// Assumes the flags are slow levels, so no pulse stretching is needed.
module thsd_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    // Shift the flags through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];

    // R2: the output is the previous stage delayed by one edge
    assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> sync_o == $past(chain_q[STAGES-2]));
endmodule

// File: rtl/thsd_select.sv
// Picks the set of channels to disable from the per-channel heavy-load
// flags. If no channel is heavy, every channel is selected.
// Assumes the flags are synchronous to the controller clock.
module thsd_select #(
    parameter int NUM_CH = 2
) (
    input  logic [NUM_CH-1:0] heavy_i,
    output logic [NUM_CH-1:0] pick_o
);
    logic none_heavy;

    // Detect the no-heavy-channel case (R5 fallback).
    always_comb none_heavy = (heavy_i == '0);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_pick
            assign pick_o[gi] = heavy_i[gi] | none_heavy;
        end
    endgenerate

    // R3/R5: the selected set is never empty
    always_comb assert_pick_nonempty_R5: assert (pick_o != '0);
endmodule

// File: rtl/thsd_ctrl.sv
// Trip/release state machine. It captures the selected set on overheat
// entry and holds it until cool-down with overheat low, then clears the
// disables and emits a one-cycle restart for each released channel.
// Assumes hot_s and cool_s are already synchronized.
module thsd_ctrl
    import thsd_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hot_s,
    input  logic              cool_s,
    input  logic [NUM_CH-1:0] pick_i,
    output logic [NUM_CH-1:0] off_o,
    output logic [NUM_CH-1:0] restart_o
);
    trip_state_e       state_q;
    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] restart_q;
    logic              enter, leave;

    // Entry and release conditions; hot has priority over cool (R7).
    always_comb begin
        enter = (state_q == ST_RUN)  && hot_s;
        leave = (state_q == ST_TRIP) && cool_s && !hot_s;
    end

    // State, captured set and restart pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            mask_q    <= '0;
            restart_q <= '0;
        end else begin
            restart_q <= '0;
            if (enter) begin
                state_q <= ST_TRIP;
                mask_q  <= pick_i;
            end else if (leave) begin
                state_q   <= ST_RUN;
                mask_q    <= '0;
                restart_q <= mask_q;
            end
        end
    end

    assign off_o     = mask_q;
    assign restart_o = restart_q;

    // R6: the captured set is stable while the trip is held
    assert_hold_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_TRIP && state_q == ST_TRIP) |-> $stable(off_o));
    // R8: the restart pulse lasts one cycle
    assert_restart_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_o != '0) |=> (restart_o == '0));
    // R8: restart only for channels that were disabled the cycle before
    assert_restart_subset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_o != '0) |-> ((restart_o & ~$past(off_o)) == '0) && (off_o == '0));
    // R3: the captured set equals the selection presented at entry
    assert_entry_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_TRIP) |-> off_o == $past(pick_i));
    // R7: no release while synchronized overheat is high
    assert_no_release_hot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_TRIP && $past(hot_s)) |-> state_q == ST_TRIP);
    // R1: nothing disabled while running
    assert_run_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> off_o == '0);
endmodule

// File: rtl/therm_guard.sv
// Selective thermal shutdown controller top. Synchronizes the two
// temperature flags, selects the channels to disable and runs the
// trip/release state machine.
// Assumes heavy_i is synchronous to clk.
module therm_guard #(
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hot_i,
    input  logic              cool_i,
    input  logic [NUM_CH-1:0] heavy_i,
    output logic [NUM_CH-1:0] therm_off_o,
    output logic [NUM_CH-1:0] restart_o
);
    logic [1:0]        flags_s;
    logic [NUM_CH-1:0] pick;

    thsd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cool_i, hot_i}),
        .sync_o  (flags_s)
    );

    thsd_select #(.NUM_CH(NUM_CH)) u_select (
        .heavy_i (heavy_i),
        .pick_o  (pick)
    );

    thsd_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hot_s     (flags_s[0]),
        .cool_s    (flags_s[1]),
        .pick_i    (pick),
        .off_o     (therm_off_o),
        .restart_o (restart_o)
    );
endmodule

// File: tb/therm_guard_bench.sv
// Directed bench for the selective thermal shutdown controller.
module therm_guard_bench;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           hot, cool;
    logic [NCH-1:0] heavy;
    logic [NCH-1:0] off, rst_pulse;
    int             checks = 0;
    int             errors = 0;
    bit             done = 0;

    therm_guard #(.NUM_CH(NCH)) u_therm_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .hot_i       (hot),
        .cool_i      (cool),
        .heavy_i     (heavy),
        .therm_off_o (off),
        .restart_o   (rst_pulse)
    );

    always #5 clk = ~clk;

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [NCH-1:0] act,
                       input logic [NCH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Trip with a given load pattern, checking latency and the chosen set.
    task automatic trip(input string req, input logic [NCH-1:0] hv,
                        input logic [NCH-1:0] exp);
        heavy = hv;
        hot   = 1'b1;
        wait_edges(2);
        chk("R2 trip not yet", off, '0);
        wait_edges(1);
        chk(req, off, exp);
        chk("R8 no restart on trip", rst_pulse, '0);
        hot = 1'b0;
    endtask

    // Release, checking latency and a one-cycle restart of the held set.
    task automatic release_chk(input logic [NCH-1:0] held);
        cool = 1'b1;
        wait_edges(2);
        chk("R2 release not yet", off, held);
        wait_edges(1);
        chk("R8 off cleared", off, '0);
        chk("R8 restart set", rst_pulse, held);
        wait_edges(1);
        chk("R8 restart one cycle", rst_pulse, '0);
        cool = 1'b0;
        wait_edges(3);
    endtask

    task automatic test_reset();
        rst_n = 1'b0; hot = 1'b0; cool = 1'b0; heavy = '0;
        wait_edges(3);
        chk("R1 off in reset", off, '0);
        chk("R1 restart in reset", rst_pulse, '0);
        rst_n = 1'b1;
        wait_edges(1);
        chk("R1 off after reset", off, '0);
    endtask

    task automatic test_selective();
        trip("R3 only ch0 heavy", 2'b01, 2'b01);
        heavy = 2'b10;
        wait_edges(4);
        chk("R6 held despite load change", off, 2'b01);
        release_chk(2'b01);
        trip("R3 only ch1 heavy", 2'b10, 2'b10);
        release_chk(2'b10);
    endtask

    task automatic test_all_heavy();
        trip("R4 all heavy", 2'b11, 2'b11);
        release_chk(2'b11);
    endtask

    task automatic test_none_heavy();
        trip("R5 none heavy", 2'b00, 2'b11);
        heavy = 2'b01;
        wait_edges(3);
        chk("R6 held after none heavy", off, 2'b11);
        release_chk(2'b11);
    endtask

    task automatic test_cool_ignored();
        cool = 1'b1;
        wait_edges(5);
        chk("R7 cool while running off", off, '0);
        chk("R7 cool while running restart", rst_pulse, '0);
        cool = 1'b0;
        wait_edges(3);
        heavy = 2'b10;
        hot   = 1'b1;
        wait_edges(3);
        chk("R3 trip for hot-priority test", off, 2'b10);
        cool = 1'b1;
        wait_edges(5);
        chk("R7 cool while hot off", off, 2'b10);
        chk("R7 cool while hot restart", rst_pulse, '0);
        hot = 1'b0;
        wait_edges(2);
        chk("R2 release waits for hot sync", off, 2'b10);
        wait_edges(1);
        chk("R8 release after hot low", rst_pulse, 2'b10);
        chk("R8 off clear after hot low", off, '0);
        cool = 1'b0;
        wait_edges(3);
    endtask

    task automatic test_retrip();
        trip("R9 first trip", 2'b01, 2'b01);
        release_chk(2'b01);
        trip("R9 new capture", 2'b11, 2'b11);
        release_chk(2'b11);
    endtask

    initial begin
        test_reset();
        test_selective();
        test_all_heavy();
        test_none_heavy();
        test_cool_ignored();
        test_retrip();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule